// File: doc/BRIEF.md
# Bordered Raster Timing Generator

This block produces the horizontal and vertical timing of a raster video output. A programmable border rectangle is nested inside the full line and field totals, and a display window is nested inside the border. Outside the window but inside the border the block drives the border colour. Inside the window it marks the cycles on which a pixel is wanted. Sync pulses, a field flag for interlaced output, the beam position and a one-cycle retrace event complete the outputs.

Configuration arrives as plain register words with fixed field positions. The window start words pass through shadow copies. These copies reload only at the start of a frame, or at any time while video output is switched off, so software writes never tear a displayed frame. Mode bits select the pixel rate, horizontal pixel doubling, scan doubling, interlace and blanking.

The pixel-request strobe carries no back-pressure. The fetch logic that consumes it must accept one pixel on every cycle the strobe is high. Every other pin is a plain level or pulse.

Top module: `bordered_raster_gen`

## Requirements
- R1: `sync_totals` holds the vertical total in [25:16] and the horizontal total in [9:0]. `beam_x` counts 0 to htotal-1 and `beam_y` counts 0 to vtotal-1, each wrapping to 0 after its last count.
- R2: With `mode_cfg` bit 23 set, the position advances on every clock. With it clear, the position advances on every second clock, so each position lasts two clocks.
- R3: `border_h` and `border_v` each hold the start in [25:16] and the stop in [9:0]. `in_border` is high when start <= position < stop on both axes, `mode_cfg` bit 0 (display enable) is set and video is enabled.
- R4: `win_hstart` [9:0] gives the window's first column. `win_vstart` gives the first row for field 0 in [25:16] and for field 1 in [9:0]. `in_window` is high when `in_border` is high, both positions are at or past the window start, and the output is not blanked. `border_rgb` equals `border_colour` when `in_border` is high and `in_window` is low, and is 0 otherwise.
- R5: Setting `win_cfg` bit 3 forces `in_window` and `pix_req` low, so the border colour fills the whole bordered area.
- R6: `pix_req` pulses once per window position. With `win_cfg` bit 0 set, it pulses only on window columns at an even distance from the window start, so each fetched pixel covers two columns.
- R7: With `mode_cfg` bit 1 set, each row count is held for two lines, so a frame lasts 2*vtotal lines.
- R8: With `sync_cfg` bit 4 set, `field` toggles at every frame end, and field 1 is one line short (vtotal-1 lines). With bit 4 clear, `field` is 0.
- R9: While `sync_cfg` bit 8 (video enable) is clear, the position and field are held at 0, and all flags, syncs, strobes and the colour output are low.
- R10: `vblank_evt` is high for one cycle at position (0,0) at the start of each frame. The window start words are taken from the inputs only at that point, or while video is disabled. Changes made mid-frame take effect from the next frame.
- R11: `hsync` is high while `beam_x` < HSYNC_W and `vsync` is high while `beam_y` < VSYNC_W, both only while video is enabled.
- R12: During and after reset, with all inputs at 0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_totals | input | 32 | Vertical total [25:16], horizontal total [9:0] |
| border_h | input | 32 | Border horizontal start [25:16], stop [9:0] |
| border_v | input | 32 | Border vertical start [25:16], stop [9:0] |
| win_hstart | input | 32 | Window first column [9:0] (shadowed) |
| win_vstart | input | 32 | Window first row, field 0 [25:16], field 1 [9:0] (shadowed) |
| win_cfg | input | 32 | Bit 3 blank, bit 0 horizontal pixel doubling |
| mode_cfg | input | 32 | Bit 23 full pixel rate, bit 1 scan doubling, bit 0 display enable |
| sync_cfg | input | 32 | Bit 8 video enable, bit 4 interlace |
| border_colour | input | RGB_W | Colour driven in the border |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| field | output | 1 | Current interlace field |
| in_border | output | 1 | Beam inside the border rectangle |
| in_window | output | 1 | Beam inside the display window |
| pix_req | output | 1 | Pixel request strobe |
| vblank_evt | output | 1 | One-cycle start-of-frame retrace event |
| beam_x | output | 10 | Horizontal position |
| beam_y | output | 10 | Vertical position |
| border_rgb | output | RGB_W | Border colour or 0 |

## Verification
One fixed geometry is run under eight mode patterns. Each pattern is measured over a whole frame by counting clocks, pixel requests, window cycles, border-colour cycles and field-high cycles. Full rate and half rate are told apart by doubled clock and colour counts with an unchanged request count. Pixel doubling halves only the requests, blanking moves every window position into the border count, and scan doubling doubles both lines and requests. Interlace is told apart by a shorter field-1 frame with a lower window top, followed by a normal field-0 frame. Directed runs change the window start mid-frame to expose the shadow timing, and switch video off to check that everything is held at rest.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int REG_W = 32;
  localparam int FW    = 10;

  localparam int MODE_DEN  = 0;
  localparam int MODE_SCAN = 1;
  localparam int MODE_CLK  = 23;
  localparam int WCFG_PDBL = 0;
  localparam int WCFG_BLNK = 3;
  localparam int SYNC_ILC  = 4;
  localparam int SYNC_VEN  = 8;

  typedef struct packed {
    logic ven;
    logic den;
    logic clk_full;
    logic scan_dbl;
    logic ilace;
    logic blank;
    logic pix_dbl;
  } mode_t;

  function automatic logic [FW-1:0] hi_field(input logic [REG_W-1:0] w);
    return w[16 +: FW];
  endfunction

  function automatic logic [FW-1:0] lo_field(input logic [REG_W-1:0] w);
    return w[0 +: FW];
  endfunction
endpackage

// File: rtl/rg_hcount.sv
module rg_hcount
  import raster_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clk_full,
  input  logic [FW-1:0] htot,
  output logic          tick,
  output logic [FW-1:0] hcnt,
  output logic          line_end
);
  localparam logic [FW-1:0] ONE = 1;
  logic          phase;
  logic [FW-1:0] hlast;

  assign hlast    = (htot == '0) ? '0 : htot - ONE;
  assign tick     = run & (clk_full | phase);
  assign line_end = tick & (hcnt >= hlast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 1'b0;
      hcnt  <= '0;
    end else if (!run) begin
      phase <= 1'b0;
      hcnt  <= '0;
    end else begin
      phase <= ~phase;
      if (tick) hcnt <= line_end ? '0 : hcnt + ONE;
    end
  end

  // R2: the position only moves on a pixel tick
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(hcnt));
endmodule

// File: rtl/rg_vcount.sv
module rg_vcount
  import raster_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          line_end,
  input  logic          scan_dbl,
  input  logic          ilace,
  input  logic [FW-1:0] vtot,
  output logic [FW-1:0] vcnt,
  output logic          field,
  output logic          frame_end
);
  localparam logic [FW-1:0] ONE = 1;
  localparam logic [FW-1:0] TWO = 2;
  logic          rep;
  logic          adv;
  logic [FW-1:0] vlast;

  always_comb begin
    if (ilace && field) vlast = (vtot < TWO) ? '0 : vtot - TWO;
    else                vlast = (vtot == '0) ? '0 : vtot - ONE;
  end

  assign adv       = line_end & (~scan_dbl | rep);
  assign frame_end = adv & (vcnt >= vlast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep   <= 1'b0;
      vcnt  <= '0;
      field <= 1'b0;
    end else if (!run) begin
      rep   <= 1'b0;
      vcnt  <= '0;
      field <= 1'b0;
    end else if (line_end) begin
      rep <= scan_dbl ? ~rep : 1'b0;
      if (adv) vcnt <= frame_end ? '0 : vcnt + ONE;
      if (frame_end) field <= ilace ? ~field : 1'b0;
    end
  end

  // R8: interlace alternates the field at each frame end
  assert_field_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && ilace) |=> (field != $past(field)));
  // R8: progressive output stays on field 0
  assert_field_flat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !ilace) |=> !field);
endmodule

// File: rtl/rg_region.sv
module rg_region
  import raster_pkg::*;
#(
  parameter int RGB_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shown,
  input  logic             blank,
  input  logic             pix_dbl,
  input  logic             tick,
  input  logic [FW-1:0]    hcnt,
  input  logic [FW-1:0]    vcnt,
  input  logic [FW-1:0]    bh_start,
  input  logic [FW-1:0]    bh_stop,
  input  logic [FW-1:0]    bv_start,
  input  logic [FW-1:0]    bv_stop,
  input  logic [FW-1:0]    wh_start,
  input  logic [FW-1:0]    wv_start,
  input  logic [RGB_W-1:0] colour,
  output logic             in_border,
  output logic             in_window,
  output logic             pix_req,
  output logic [RGB_W-1:0] border_rgb
);
  logic h_in, v_in, col_even;

  assign h_in      = (hcnt >= bh_start) && (hcnt < bh_stop);
  assign v_in      = (vcnt >= bv_start) && (vcnt < bv_stop);
  assign in_border = shown & h_in & v_in;
  assign in_window = in_border & ~blank & (hcnt >= wh_start) & (vcnt >= wv_start);
  assign col_even  = ~(hcnt[0] ^ wh_start[0]);
  assign pix_req   = in_window & tick & (~pix_dbl | col_even);
  assign border_rgb = (in_border && !in_window) ? colour : '0;

  // R4: the window never extends past the border
  assert_win_in_border_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_window |-> in_border);
  // R5: blanking removes the window
  assert_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> !in_window);
  // R6: requests only fall inside the window
  assert_pix_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_req |-> in_window);
endmodule

// File: rtl/bordered_raster_gen.sv
module bordered_raster_gen
  import raster_pkg::*;
#(
  parameter int HSYNC_W = 2,
  parameter int VSYNC_W = 1,
  parameter int RGB_W   = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] sync_totals,
  input  logic [REG_W-1:0] border_h,
  input  logic [REG_W-1:0] border_v,
  input  logic [REG_W-1:0] win_hstart,
  input  logic [REG_W-1:0] win_vstart,
  input  logic [REG_W-1:0] win_cfg,
  input  logic [REG_W-1:0] mode_cfg,
  input  logic [REG_W-1:0] sync_cfg,
  input  logic [RGB_W-1:0] border_colour,
  output logic             hsync,
  output logic             vsync,
  output logic             field,
  output logic             in_border,
  output logic             in_window,
  output logic             pix_req,
  output logic             vblank_evt,
  output logic [FW-1:0]    beam_x,
  output logic [FW-1:0]    beam_y,
  output logic [RGB_W-1:0] border_rgb
);
  localparam logic [FW-1:0] HS_LIM = FW'(HSYNC_W);
  localparam logic [FW-1:0] VS_LIM = FW'(VSYNC_W);

  mode_t         md;
  logic          tick, line_end, frame_end;
  logic [FW-1:0] hcnt, vcnt;
  logic [FW-1:0] win_h_act, win_v0_act, win_v1_act;
  logic          unused_bits;

  assign md.ven      = sync_cfg[SYNC_VEN];
  assign md.ilace    = sync_cfg[SYNC_ILC];
  assign md.den      = mode_cfg[MODE_DEN];
  assign md.scan_dbl = mode_cfg[MODE_SCAN];
  assign md.clk_full = mode_cfg[MODE_CLK];
  assign md.blank    = win_cfg[WCFG_BLNK];
  assign md.pix_dbl  = win_cfg[WCFG_PDBL];

  assign unused_bits = ^{sync_totals[31:26], sync_totals[15:10], border_h[31:26],
                         border_h[15:10], border_v[31:26], border_v[15:10],
                         win_hstart[31:10], win_vstart[31:26], win_vstart[15:10],
                         win_cfg[31:4], win_cfg[2:1], mode_cfg[31:24], mode_cfg[22:2],
                         sync_cfg[31:9], sync_cfg[7:5], sync_cfg[3:0]};

  rg_hcount u_h (
    .clk(clk), .rst_n(rst_n), .run(md.ven), .clk_full(md.clk_full),
    .htot(lo_field(sync_totals)), .tick(tick), .hcnt(hcnt), .line_end(line_end)
  );

  rg_vcount u_v (
    .clk(clk), .rst_n(rst_n), .run(md.ven), .line_end(line_end),
    .scan_dbl(md.scan_dbl), .ilace(md.ilace), .vtot(hi_field(sync_totals)),
    .vcnt(vcnt), .field(field), .frame_end(frame_end)
  );

  // Shadowed window starts: reload at frame start or while output is off
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_h_act  <= '0;
      win_v0_act <= '0;
      win_v1_act <= '0;
      vblank_evt <= 1'b0;
    end else begin
      vblank_evt <= frame_end;
      if (!md.ven || frame_end) begin
        win_h_act  <= lo_field(win_hstart);
        win_v0_act <= hi_field(win_vstart);
        win_v1_act <= lo_field(win_vstart);
      end
    end
  end

  rg_region #(.RGB_W(RGB_W)) u_r (
    .clk(clk), .rst_n(rst_n), .shown(md.ven & md.den), .blank(md.blank),
    .pix_dbl(md.pix_dbl), .tick(tick), .hcnt(hcnt), .vcnt(vcnt),
    .bh_start(hi_field(border_h)), .bh_stop(lo_field(border_h)),
    .bv_start(hi_field(border_v)), .bv_stop(lo_field(border_v)),
    .wh_start(win_h_act), .wv_start(field ? win_v1_act : win_v0_act),
    .colour(border_colour), .in_border(in_border), .in_window(in_window),
    .pix_req(pix_req), .border_rgb(border_rgb)
  );

  assign hsync  = md.ven & (hcnt < HS_LIM);
  assign vsync  = md.ven & (vcnt < VS_LIM);
  assign beam_x = hcnt;
  assign beam_y = vcnt;

  // R10: the retrace event marks the frame origin
  assert_evt_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_evt |-> (beam_x == '0 && beam_y == '0));
  // R10: active window start is frozen between frame starts
  assert_shadow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(md.ven) && !vblank_evt) |-> $stable(win_h_act));
  // R9: disabled output rests at the origin
  assert_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !md.ven |=> (beam_x == '0 && beam_y == '0 && !field));
endmodule

// File: tb/bordered_raster_gen_test.sv
module bordered_raster_gen_test;
  localparam logic [23:0] COL = 24'hABCDEF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] sync_totals = '0, border_h = '0, border_v = '0, win_hstart = '0;
  logic [31:0] win_vstart = '0, win_cfg = '0, mode_cfg = '0, sync_cfg = '0;
  logic [23:0] border_colour = '0;
  logic        hsync, vsync, field, in_border, in_window, pix_req, vblank_evt;
  logic [9:0]  beam_x, beam_y;
  logic [23:0] border_rgb;

  int checks = 0, errors = 0;
  int n_clk, n_pix, n_win, n_bord, n_fld, n_hs, n_vs, n_bad, max_x, max_y;

  always #10 clk = ~clk;

  bordered_raster_gen uut (
    .clk(clk), .rst_n(rst_n), .sync_totals(sync_totals), .border_h(border_h),
    .border_v(border_v), .win_hstart(win_hstart), .win_vstart(win_vstart),
    .win_cfg(win_cfg), .mode_cfg(mode_cfg), .sync_cfg(sync_cfg),
    .border_colour(border_colour), .hsync(hsync), .vsync(vsync), .field(field),
    .in_border(in_border), .in_window(in_window), .pix_req(pix_req),
    .vblank_evt(vblank_evt), .beam_x(beam_x), .beam_y(beam_y), .border_rgb(border_rgb)
  );

  // cfg {den, full rate, pixel double, scan double, interlace, blank},
  // field-high cycles, clocks, requests, window cycles, border-colour cycles
  localparam logic [63:0] VEC [8] = '{
    {6'b110000, 10'd0,   12'd240, 12'd70,  12'd70,  12'd26},  // R1 R3 R4 base
    {6'b100000, 10'd0,   12'd480, 12'd70,  12'd140, 12'd52},  // R2 half rate
    {6'b111000, 10'd0,   12'd240, 12'd35,  12'd70,  12'd26},  // R6 pixel double
    {6'b110001, 10'd0,   12'd240, 12'd0,   12'd0,   12'd96},  // R5 blank
    {6'b110100, 10'd0,   12'd480, 12'd140, 12'd140, 12'd52},  // R7 scan double
    {6'b010000, 10'd0,   12'd240, 12'd0,   12'd0,   12'd0},   // R3 display off
    {6'b110010, 10'd220, 12'd220, 12'd50,  12'd50,  12'd46},  // R8 field 1
    {6'b101000, 10'd0,   12'd480, 12'd35,  12'd140, 12'd52}   // R2 R6 combined
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [5:0] c, input int wh);
    sync_cfg = '0;
    repeat (2) @(negedge clk);
    sync_totals   = (32'd12 << 16) | 32'd20;
    border_h      = (32'd4 << 16) | 32'd16;
    border_v      = (32'd2 << 16) | 32'd10;
    win_hstart    = 32'(wh);
    win_vstart    = (32'd3 << 16) | 32'd5;
    border_colour = COL;
    win_cfg       = {28'd0, c[0], 2'b00, c[3]};
    mode_cfg      = {8'd0, c[4], 21'd0, c[2], c[5]};
    sync_cfg      = {23'd0, 1'b1, 3'd0, c[1], 4'd0};
  endtask

  task automatic wait_evt();
    int lim = 0;
    @(negedge clk);
    while (!vblank_evt && lim < 2000) begin
      @(negedge clk);
      lim++;
    end
  endtask

  // counts from the current (event) cycle up to the cycle before the next event
  task automatic count_frame();
    n_clk = 0; n_pix = 0; n_win = 0; n_bord = 0; n_fld = 0;
    n_hs = 0; n_vs = 0; n_bad = 0; max_x = 0; max_y = 0;
    do begin
      n_clk++;
      if (pix_req) n_pix++;
      if (in_window) n_win++;
      if (border_rgb == COL) n_bord++;
      if (border_rgb != COL && border_rgb != '0) n_bad++;
      if (in_window && border_rgb != '0) n_bad++;
      if (field) n_fld++;
      if (hsync) n_hs++;
      if (vsync) n_vs++;
      if (int'(beam_x) > max_x) max_x = int'(beam_x);
      if (int'(beam_y) > max_y) max_y = int'(beam_y);
      @(negedge clk);
    end while (!vblank_evt && n_clk < 5000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R12 reset state
    repeat (3) @(negedge clk);
    chk("R12 outputs in reset", int'({hsync, vsync, field, in_border, in_window,
        pix_req, vblank_evt, beam_x, beam_y, border_rgb} != '0), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 outputs after reset", int'({hsync, vsync, field, in_border, in_window,
        pix_req, vblank_evt, beam_x, beam_y, border_rgb} != '0), 0);

    foreach (VEC[i]) begin
      apply(VEC[i][63:58], 6);
      wait_evt();
      chk("R10 event at origin", int'(beam_x) + int'(beam_y), 0);
      count_frame();
      chk("R1 R2 R7 R8 frame clocks", n_clk, int'(VEC[i][47:36]));
      chk("R6 pixel requests", n_pix, int'(VEC[i][35:24]));
      chk("R4 R5 window cycles", n_win, int'(VEC[i][23:12]));
      chk("R3 R4 border colour cycles", n_bord, int'(VEC[i][11:0]));
      chk("R8 field cycles", n_fld, int'(VEC[i][57:48]));
      chk("R4 colour integrity", n_bad, 0);
      if (i == 0) begin
        chk("R1 max beam_x", max_x, 19);
        chk("R1 max beam_y", max_y, 11);
        chk("R11 hsync cycles", n_hs, 24);
        chk("R11 vsync cycles", n_vs, 20);
      end
      if (i == 4) chk("R7 max beam_y", max_y, 11);
      if (i == 6) begin
        count_frame();
        chk("R8 field 0 clocks", n_clk, 240);
        chk("R8 field 0 window", n_win, 70);
        chk("R8 field 0 flag", n_fld, 0);
      end
    end

    // R10: a mid-frame window change waits for the next frame
    apply(6'b110000, 6);
    wait_evt();
    win_hstart = 32'd10;
    count_frame();
    chk("R10 old window kept", n_win, 70);
    count_frame();
    chk("R10 new window used", n_win, 42);

    // R9: video disabled holds everything at rest
    sync_cfg = '0;
    repeat (2) @(negedge clk);
    n_bad = 0;
    for (int k = 0; k < 20; k++) begin
      if ({hsync, vsync, field, in_border, in_window, pix_req, vblank_evt,
           beam_x, beam_y, border_rgb} != '0) n_bad++;
      @(negedge clk);
    end
    chk("R9 idle outputs", n_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule